// File: doc/BRIEF.md
# Configurable Input Capture Glitch Filter

This block cleans up a raw timer capture input before edge detection sees it. It takes samples of the pin at a chosen rate. It moves its output to a new level only after a run of consecutive samples all show that level. A 4-bit filter code selects two things from a fixed table: the sampling rate and the run length N. The rate is either every cycle of the timer clock, or a division by 1, 2, 8 or 16 of a sampling-tick enable that comes from the dead-time clock.

Integration is simple. Feed the block the timer clock and a one-cycle `dtsTick` pulse for every dead-time clock period. Connect the raw pin and the filter code. Take `filtOut` as the cleaned level. The pin is expected to be already synchronous to `clk`. Edge detection and capture are handled downstream.

Top module: `icf_top`

## Requirements
- R1: While `rstN` is low and after its release, `filtOut` is 0 until a filter event moves it.
- R2: Code 4'b0000 is pass-through at the tick rate. On every clock edge with `dtsTick` high, `filtOut` takes the `pinIn` level, visible after that edge. It does not change on other edges.
- R3: Codes 4'b0001, 4'b0010 and 4'b0011 sample `pinIn` on every clock edge, regardless of `dtsTick`. They require N = 2, 4 and 8 respectively.
- R4: Code 4'b0100 samples on every 2nd `dtsTick` and requires N = 6.
- R5: Codes 4'b1000 and 4'b1001 sample on every 8th `dtsTick`. They require N = 6 and N = 8 respectively.
- R6: Codes 4'b1010 and 4'b1011 sample on every 16th `dtsTick`. They require N = 5 and N = 6 respectively.
- R7: A sample equal to the current `filtOut` clears the run count. `filtOut` inverts only after N consecutive samples that all differ from it. A shorter glitch leaves it unchanged.
- R8: Codes that are not listed (4'b0101 to 4'b0111 and 4'b1100 to 4'b1111) behave exactly like 4'b0000.
- R9: In a cycle where `filtCode` differs from its value in the previous cycle, no sample is taken, and the run count and the tick divider are cleared. The first sample under the new code then falls on the ratio-th `dtsTick` after that cycle (every cycle for the clock-rate codes). Before the first edge after reset, the previous code counts as 4'b0000.
- R10: `filtOut` changes at the same clock edge that takes the N-th qualifying sample. There is no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dtsTick | input | 1 | One-cycle enable per dead-time sampling clock period |
| pinIn | input | 1 | Raw capture pin level, synchronous to clk |
| filtCode | input | 4 | Filter code selecting sample rate and run length |
| filtOut | output | 1 | Filtered input level |

## Verification
Two events can fall in the same cycle: a change of filter code and a sample that would complete a run (or land on a divider tick). The bench provokes this by switching codes on the very edge where a pending run would reach N, and on the edge where a divided tick is due. A behavioural model then has to agree, cycle by cycle, that the clear wins: the output holds, and the count and the divider restart. Exact run lengths, and glitches one sample short of N, are judged the same way under every code group.

// File: rtl/icf_pkg.sv
package icf_pkg;

  localparam int CODE_W  = 4;
  localparam int RATIO_W = 5;   // holds division ratios up to 16
  localparam int RUN_W   = 4;   // holds run lengths up to 8

  typedef struct packed {
    logic sample;   // take one sample of the pin this cycle
    logic clear;    // wipe run count (code just changed)
  } icfStrobe_t;

  typedef struct packed {
    logic               clkRate;   // sample on every clock
    logic [RATIO_W-1:0] divRatio;  // ticks per sample otherwise
    logic [RUN_W-1:0]   runLen;    // samples needed to flip
  } icfMode_t;

  function automatic icfMode_t decodeMode(input logic [CODE_W-1:0] code);
    icfMode_t m;
    m.clkRate  = 1'b0;
    m.divRatio = RATIO_W'(1);
    m.runLen   = RUN_W'(1);
    unique case (code)
      4'b0001: begin m.clkRate = 1'b1; m.runLen = RUN_W'(2); end
      4'b0010: begin m.clkRate = 1'b1; m.runLen = RUN_W'(4); end
      4'b0011: begin m.clkRate = 1'b1; m.runLen = RUN_W'(8); end
      4'b0100: begin m.divRatio = RATIO_W'(2);  m.runLen = RUN_W'(6); end
      4'b1000: begin m.divRatio = RATIO_W'(8);  m.runLen = RUN_W'(6); end
      4'b1001: begin m.divRatio = RATIO_W'(8);  m.runLen = RUN_W'(8); end
      4'b1010: begin m.divRatio = RATIO_W'(16); m.runLen = RUN_W'(5); end
      4'b1011: begin m.divRatio = RATIO_W'(16); m.runLen = RUN_W'(6); end
      default: ;  // pass-through at tick rate
    endcase
    return m;
  endfunction

endpackage

// File: rtl/icf_ctrl.sv
module icf_ctrl
  import icf_pkg::*;
#(
  parameter int CODE_BITS  = CODE_W,
  parameter int RATIO_BITS = RATIO_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dtsTick,
  input  logic [CODE_BITS-1:0] filtCode,
  output icfStrobe_t           stb,
  output logic [RUN_W-1:0]     runLen
);

  logic [CODE_BITS-1:0]  prevCode;
  logic [RATIO_BITS-1:0] divCnt;
  logic                  codeChg;
  logic                  divWrap;
  icfMode_t              mode;

  always_comb begin
    mode    = decodeMode(CODE_W'(filtCode));
    codeChg = (filtCode != prevCode);
    divWrap = (divCnt == RATIO_BITS'(mode.divRatio - 1'b1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCode <= '0;
    else       prevCode <= filtCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      divCnt <= '0;
    else if (codeChg)
      divCnt <= '0;
    else if (!mode.clkRate && dtsTick)
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    stb.clear  = codeChg;
    stb.sample = !codeChg && (mode.clkRate || (dtsTick && divWrap));
    runLen     = mode.runLen;
  end

  // R9
  div_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!codeChg && !mode.clkRate) |-> (RATIO_W'(divCnt) < mode.divRatio));

  // R9
  code_change_restarts_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeChg |=> (divCnt == '0));

endmodule

// File: rtl/icf_datapath.sv
module icf_datapath
  import icf_pkg::*;
#(
  parameter int RUN_BITS = RUN_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  icfStrobe_t          stb,
  input  logic [RUN_BITS-1:0] runLen,
  input  logic                pinIn,
  output logic                filtOut
);

  logic [RUN_BITS-1:0] runCnt;
  logic [RUN_BITS-1:0] nextCnt;

  assign nextCnt = runCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      filtOut <= 1'b0;
    end else if (stb.clear) begin
      runCnt  <= '0;
    end else if (stb.sample) begin
      if (pinIn == filtOut) begin
        runCnt <= '0;
      end else if (nextCnt >= runLen) begin
        runCnt  <= '0;
        filtOut <= ~filtOut;
      end else begin
        runCnt <= nextCnt;
      end
    end
  end

  // R7
  run_below_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clear |-> (runCnt < runLen));

  // R10
  hold_without_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sample |=> $stable(filtOut));

  // R7
  match_resets_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && (pinIn == filtOut)) |=> ((runCnt == '0) && $stable(filtOut)));

  // R9
  clear_zeroes_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (runCnt == '0));

endmodule

// File: rtl/icf_top.sv
module icf_top
  import icf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dtsTick,
  input  logic              pinIn,
  input  logic [CODE_W-1:0] filtCode,
  output logic              filtOut
);

  icfStrobe_t       stb;
  logic [RUN_W-1:0] runLen;

  icf_ctrl #(
    .CODE_BITS  (CODE_W),
    .RATIO_BITS (RATIO_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dtsTick  (dtsTick),
    .filtCode (filtCode),
    .stb      (stb),
    .runLen   (runLen)
  );

  icf_datapath #(
    .RUN_BITS (RUN_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .runLen  (runLen),
    .pinIn   (pinIn),
    .filtOut (filtOut)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) $rose(rstN) |-> (filtOut == 1'b0));

endmodule

// File: tb/tb_icf_top.sv
module tb_icf_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dtsTick = 1'b0;
  logic       pinIn = 1'b0;
  logic [3:0] filtCode = 4'b0000;
  logic       filtOut;

  int  checks = 0;
  int  fails = 0;
  int  tickGap = 3;
  int  tickPhase = 0;
  bit  finished = 0;
  string curReq = "R1";

  // behavioural model state
  int  mPrev = 0;
  int  mDiv = 0;
  int  mRun = 0;
  bit  mOut = 0;

  icf_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .dtsTick  (dtsTick),
    .pinIn    (pinIn),
    .filtCode (filtCode),
    .filtOut  (filtOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // sampling-tick source: one pulse every tickGap clocks
  always @(negedge clk) begin
    tickPhase = (tickPhase + 1) % tickGap;
    dtsTick  <= (tickPhase == 0);
  end

  function automatic int ratioOf(input int code);
    if (code >= 1 && code <= 3) return 0;   // 0 means every clock
    if (code == 4) return 2;
    if (code == 8 || code == 9) return 8;
    if (code == 10 || code == 11) return 16;
    return 1;
  endfunction

  function automatic int needOf(input int code);
    int table_n [16] = '{1, 2, 4, 8, 6, 1, 1, 1, 6, 8, 5, 6, 1, 1, 1, 1};
    return table_n[code];
  endfunction

  // reference model, updated on each edge from inputs held since the last negedge
  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 0; mDiv = 0; mRun = 0; mOut = 0;
    end else begin
      int code;
      bit take;
      code = int'(filtCode);
      take = 0;
      if (code != mPrev) begin
        mRun = 0; mDiv = 0;
      end else if (ratioOf(code) == 0) begin
        take = 1;
      end else if (dtsTick) begin
        mDiv = mDiv + 1;
        if (mDiv == ratioOf(code)) begin
          take = 1; mDiv = 0;
        end
      end
      if (take) begin
        if (pinIn == mOut) mRun = 0;
        else begin
          mRun = mRun + 1;
          if (mRun >= needOf(code)) begin
            mOut = !mOut; mRun = 0;
          end
        end
      end
      mPrev = code;
    end
  end

  // per-clock comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && !finished) begin
      checks++;
      if (filtOut !== mOut) begin
        fails++;
        $display("FAIL %s: filtOut=%0b expected %0b at %0t", curReq, filtOut, mOut, $time);
      end
    end
  end

  task automatic hold(input bit level, input int cycles);
    pinIn = level;
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  task automatic setCode(input logic [3:0] c);
    filtCode = c;
    @(negedge clk);
  endtask

  task automatic directCheck(input string req, input bit expVal);
    checks++;
    if (filtOut !== expVal) begin
      fails++;
      $display("FAIL %s: filtOut=%0b expected %0b at %0t", req, filtOut, expVal, $time);
    end
  endtask

  task automatic glitchSweep(input int maxLen, input int unit);
    for (int len = 1; len <= maxLen; len++) begin
      hold(!mOut, len * unit);
      hold(mOut, 3 * unit);
    end
  endtask

  task automatic pattern(input int cycles, input int seed);
    int s = seed;
    for (int i = 0; i < cycles; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      pinIn = s[9];
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    directCheck("R1", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    directCheck("R1", 1'b0);

    // R2: pass-through at tick rate
    curReq = "R2";
    tickGap = 3;
    pattern(120, 7);
    hold(1, 8);
    directCheck("R2", 1'b1);
    hold(0, 8);
    directCheck("R2", 1'b0);

    // R3: clock-rate codes, ticks irrelevant
    curReq = "R3";
    tickGap = 5;
    setCode(4'b0001); glitchSweep(3, 1); pattern(150, 11);
    setCode(4'b0010); glitchSweep(5, 1); pattern(150, 12);
    setCode(4'b0011); glitchSweep(9, 1); pattern(200, 13);

    // R10: flip on the edge taking the N-th sample (code 0001, N=2)
    curReq = "R10";
    setCode(4'b0001);
    hold(0, 4);
    pinIn = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    directCheck("R10", 1'b0);
    @(posedge clk); #(CLK_PERIOD/4);
    directCheck("R10", 1'b1);
    @(negedge clk);

    // R7: run broken by a matching sample restarts the count
    curReq = "R7";
    setCode(4'b0010);
    hold(1, 6);
    hold(0, 3); hold(1, 1); hold(0, 3); hold(1, 2);
    directCheck("R7", 1'b1);
    hold(0, 6);
    directCheck("R7", 1'b0);
    glitchSweep(5, 1);

    // R4: every 2nd tick, N=6
    curReq = "R4";
    tickGap = 2;
    setCode(4'b0100);
    glitchSweep(7, 4); pattern(300, 21);

    // R5: every 8th tick, N=6 and N=8
    curReq = "R5";
    tickGap = 1;
    setCode(4'b1000); glitchSweep(7, 8); pattern(400, 22);
    setCode(4'b1001); glitchSweep(9, 8);

    // R6: every 16th tick, N=5 and N=6
    curReq = "R6";
    tickGap = 2;
    setCode(4'b1010); glitchSweep(6, 32); pattern(600, 23);
    setCode(4'b1011); glitchSweep(7, 32);

    // R8: unlisted codes pass through
    curReq = "R8";
    tickGap = 3;
    setCode(4'b0101); pattern(60, 31);
    setCode(4'b0111); pattern(60, 32);
    setCode(4'b1100); pattern(60, 33);
    setCode(4'b1111); pattern(60, 34);
    hold(!mOut, 4);
    directCheck("R8", mOut);

    // R9: code change on the edge that would finish a run
    curReq = "R9";
    tickGap = 1;
    setCode(4'b0010);
    hold(0, 6);
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    filtCode = 4'b0011;        // 4th sample would flip: suppressed
    @(negedge clk);
    directCheck("R9", 1'b0);
    hold(1, 7);
    directCheck("R9", 1'b0);
    hold(1, 1);
    directCheck("R9", 1'b1);
    // code change landing on a due divided tick
    setCode(4'b1000);
    for (int k = 0; k < 6; k++) begin
      hold(0, 5 + k);
      filtCode = (k % 2 == 0) ? 4'b1001 : 4'b1000;
      hold(0, 1);
      hold(1, 20 + 3 * k);
    end
    tickGap = 3;
    for (int k = 0; k < 16; k++) begin
      filtCode = 4'(k);
      pattern(40, 40 + k);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule